// File: doc/BRIEF.md
# Serial Host Register Interface

This block lets a host microcontroller reach a bank of thirty-two 8-bit control registers over four wires. The wires are an active-low select, a serial clock, a data input and a data output. The serial lines are brought into the block's own clock domain through two-stage synchronizers. The block then finds the serial clock edges by comparing successive samples, so the serial clock must be much slower than the system clock.

Each access opens when the host pulls select low. The first byte shifted in is the command. Its first bit is the direction flag, the next five bits are the register address, and the last two bits are don't-care. A data byte follows the command. On a write, the block takes the byte in from the host. On a read, the block shifts the register contents out to the host.

Every register drives a parallel output for downstream logic. Each register also has a parallel load port, so hardware can post status values that the host can then read back.

Top module: `ser_reg_host`

## Requirements
- R1: After reset, every register output is 0x00, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: A command byte with bit 7 = 0 is a write. Command bits 6..2 are the register address, most significant bit first, and command bits 1..0 are ignored. The data byte is shifted in most significant bit first, one bit per rising edge of `sclk_i`. Once the eighth data bit arrives, the addressed register takes the byte and every other register keeps its value.
- R3: A command byte with bit 7 = 1 is a read. The addressed register's value is driven on `sdo_o` most significant bit first. Each bit changes after a falling edge of `sclk_i` and is valid at the following rising edge, for the 8 rising edges after the command.
- R4: `sdo_oe_o` is 1 only during the data phase of a read with select low. It is 0 during the command byte, during a write, after the eighth read bit and while select is high. Whenever `sdo_oe_o` is 0, `sdo_o` is 0.
- R5: If select rises before the eighth data bit of a write, no register changes.
- R6: If select rises in the middle of a command byte, the bit count is cleared, and the next transaction is decoded from its first bit.
- R7: Serial clock edges after the data byte, while select is still low, change no register. Only one register is written per select period.
- R8: A high `hw_we_i[k]` loads register k from its slice of `hw_data_i` on the next clock. When a host write reaches the same register in the same clock, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csb_i | input | 1 | Active-low transaction select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| hw_we_i | input | NREG | Per-register hardware load strobe |
| hw_data_i | input | NREG*REG_W | Hardware load values, register k at bits k*REG_W +: REG_W |
| ctrl_o | output | NREG*REG_W | Register contents, register k at bits k*REG_W +: REG_W |

## Verification
The hardest case to reach from the ports is a host write and a hardware load hitting the same register in the same system clock. That clock is fixed only by the synchronizer and edge-detect stages that sit between the last rising serial clock and the register update. The bench holds the hardware strobe high from before the transaction. It then drops the strobe exactly one clock after the write lands, counted from when it raises the final serial clock. If the priority were reversed, the register would keep the hardware value, and the check would catch it. Aborts are reached by raising select at chosen bit counts, both inside the command byte and inside the data byte.

// File: rtl/ser_reg_host_pkg.sv
// Package ser_reg_host_pkg
// Shared defaults and the transaction phase type for the serial host
// register interface. Assumes an 8-bit command byte with the direction
// flag in its top bit.
package ser_reg_host_pkg;

    localparam int DEF_REG_W = 8;
    localparam int DEF_NREG  = 32;
    localparam int CMD_W     = 8;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

endpackage

// File: rtl/ser_sync.sv
// Module ser_sync
// Two-stage synchronizer for a vector of asynchronous single-bit inputs.
// Assumes each input stays at a level for at least two system clocks.
module ser_sync #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Two flops in series for each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/ser_frame_fsm.sv
// Module ser_frame_fsm
// Frames one serial transaction. It finds the serial clock edges, shifts
// in the command and write data on rising edges, and shifts read data out
// on falling edges. It issues a single write strobe per select period.
// Assumes inputs are already synchronized to clk and that the serial clock
// is slower than clk by a wide margin.
module ser_frame_fsm
    import ser_reg_host_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_s_i,
    input  logic              sclk_s_i,
    input  logic              sdi_s_i,
    input  logic [REG_W-1:0]  rd_data_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [REG_W-1:0]  wr_data_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output phase_e            phase_o
);

    localparam int CNT_W   = $clog2(CMD_W);
    localparam int LAST    = CMD_W - 1;
    localparam int ADDR_LO = CMD_W - 1 - ADDR_W;

    logic             sclk_d;
    logic             rise;
    logic             fall;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] shin_q;
    logic [CMD_W-1:0] cmd_byte;
    logic [REG_W-1:0] tx_q;
    logic             load_q;
    phase_e           phase_q;

    // Keep the previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s_i;
    end

    assign rise     = sclk_s_i & ~sclk_d;
    assign fall     = ~sclk_s_i & sclk_d;
    assign cmd_byte = {shin_q[CMD_W-2:0], sdi_s_i};

    // Phase sequencing, shifting and the output data path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_CMD;
            cnt_q     <= '0;
            shin_q    <= '0;
            tx_q      <= '0;
            load_q    <= 1'b0;
            wr_stb_o  <= 1'b0;
            addr_o    <= '0;
            wr_data_o <= '0;
            sdo_o     <= 1'b0;
            sdo_oe_o  <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            load_q   <= 1'b0;
            if (csb_s_i) begin
                phase_q  <= PH_CMD;
                cnt_q    <= '0;
                sdo_o    <= 1'b0;
                sdo_oe_o <= 1'b0;
            end else begin
                case (phase_q)
                    PH_CMD: begin
                        if (rise) begin
                            shin_q <= cmd_byte;
                            cnt_q  <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(LAST)) begin
                                addr_o  <= cmd_byte[CMD_W-2:ADDR_LO];
                                phase_q <= cmd_byte[CMD_W-1] ? PH_RD : PH_WR;
                                load_q  <= cmd_byte[CMD_W-1];
                                cnt_q   <= '0;
                            end
                        end
                    end
                    PH_WR: begin
                        if (rise) begin
                            shin_q <= cmd_byte;
                            cnt_q  <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(LAST)) begin
                                wr_stb_o  <= 1'b1;
                                wr_data_o <= cmd_byte[REG_W-1:0];
                                phase_q   <= PH_DONE;
                            end
                        end
                    end
                    PH_RD: begin
                        if (load_q) begin
                            tx_q <= rd_data_i;
                        end else if (fall) begin
                            sdo_o    <= tx_q[REG_W-1];
                            sdo_oe_o <= 1'b1;
                            tx_q     <= {tx_q[REG_W-2:0], 1'b0};
                        end
                        if (rise) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(LAST)) begin
                                phase_q  <= PH_DONE;
                                sdo_o    <= 1'b0;
                                sdo_oe_o <= 1'b0;
                            end
                        end
                    end
                    default: begin
                        cnt_q <= cnt_q;
                    end
                endcase
            end
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/ser_regbank.sv
// Module ser_regbank
// Bank of NREG registers of REG_W bits. A host write has priority over a
// hardware load to the same register in the same clock. Read data is a
// plain mux on the address.
// Assumes host_addr_i is below NREG.
module ser_regbank #(
    parameter int              REG_W   = 8,
    parameter int              NREG    = 32,
    parameter int              ADDR_W  = 5,
    parameter logic [REG_W-1:0] RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_we_i,
    input  logic [ADDR_W-1:0]     host_addr_i,
    input  logic [REG_W-1:0]      host_data_i,
    input  logic [NREG-1:0]       hw_we_i,
    input  logic [NREG*REG_W-1:0] hw_data_i,
    output logic [REG_W-1:0]      rd_data_o,
    output logic [NREG*REG_W-1:0] regs_o
);

    logic [REG_W-1:0] bank_q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        // One register: host write first, then hardware load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[gi] <= RST_VAL;
            end else if (host_we_i && (host_addr_i == ADDR_W'(gi))) begin
                bank_q[gi] <= host_data_i;
            end else if (hw_we_i[gi]) begin
                bank_q[gi] <= hw_data_i[gi*REG_W +: REG_W];
            end
        end
        assign regs_o[gi*REG_W +: REG_W] = bank_q[gi];
    end

    assign rd_data_o = bank_q[host_addr_i];

endmodule

// File: rtl/ser_reg_host.sv
// Module ser_reg_host
// Top of the serial host register interface. It synchronizes the serial
// lines, frames transactions and holds the register bank.
// Assumes the serial clock period is at least 8 system clocks and that
// select is low for at least 2 system clocks before the first rising
// serial clock edge.
module ser_reg_host
    import ser_reg_host_pkg::*;
#(
    parameter int REG_W = DEF_REG_W,
    parameter int NREG  = DEF_NREG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csb_i,
    input  logic                  sclk_i,
    input  logic                  sdi_i,
    output logic                  sdo_o,
    output logic                  sdo_oe_o,
    input  logic [NREG-1:0]       hw_we_i,
    input  logic [NREG*REG_W-1:0] hw_data_i,
    output logic [NREG*REG_W-1:0] ctrl_o
);

    localparam int ADDR_W = $clog2(NREG);

    logic [2:0]        sync_v;
    logic              csb_s;
    logic              sclk_s;
    logic              sdi_s;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [REG_W-1:0]  wr_data;
    logic [REG_W-1:0]  rd_data;
    phase_e            phase;

    ser_sync #(
        .WIDTH   (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({csb_i, sclk_i, sdi_i}),
        .sync_o  (sync_v)
    );

    assign csb_s  = sync_v[2];
    assign sclk_s = sync_v[1];
    assign sdi_s  = sync_v[0];

    ser_frame_fsm #(
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_s_i   (csb_s),
        .sclk_s_i  (sclk_s),
        .sdi_s_i   (sdi_s),
        .rd_data_i (rd_data),
        .wr_stb_o  (wr_stb),
        .addr_o    (wr_addr),
        .wr_data_o (wr_data),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o),
        .phase_o   (phase)
    );

    ser_regbank #(
        .REG_W   (REG_W),
        .NREG    (NREG),
        .ADDR_W  (ADDR_W),
        .RST_VAL ('0)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we_i   (wr_stb),
        .host_addr_i (wr_addr),
        .host_data_i (wr_data),
        .hw_we_i     (hw_we_i),
        .hw_data_i   (hw_data_i),
        .rd_data_o   (rd_data),
        .regs_o      (ctrl_o)
    );

endmodule

// File: rtl/ser_reg_host_chk.sv
// Module ser_reg_host_chk
// Property checker for ser_reg_host, attached by bind below. It relates
// the framing state, the write strobe and the register outputs over time.
module ser_reg_host_chk
    import ser_reg_host_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int NREG   = DEF_NREG,
    parameter int ADDR_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csb_s,
    input logic                  wr_stb,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [REG_W-1:0]      wr_data,
    input phase_e                phase,
    input logic                  sdo_o,
    input logic                  sdo_oe_o,
    input logic [NREG*REG_W-1:0] ctrl_o
);

    AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_s && $past(csb_s)) |-> !sdo_oe_o); // R4
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> !sdo_o); // R4
    AST_NO_DRIVE_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD) |-> !sdo_oe_o); // R4
    AST_WSTB_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(csb_s)); // R5
    AST_SINGLE_WSTB: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R7
    AST_WSTB_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (phase == PH_DONE)); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (ctrl_o[int'($past(wr_addr))*REG_W +: REG_W] == $past(wr_data))); // R2 R8

endmodule

bind ser_reg_host ser_reg_host_chk #(
    .REG_W  (REG_W),
    .NREG   (NREG),
    .ADDR_W ($clog2(NREG))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csb_s    (csb_s),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .phase    (phase),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .ctrl_o   (ctrl_o)
);

// File: tb/test_ser_reg_host.sv
// Bench for ser_reg_host: a vector table walked by one loop, then directed
// tests for reset, aborts, trailing clocks and hardware loads.
module test_ser_reg_host;

    localparam int REG_W = 8;
    localparam int NREG  = 32;
    localparam int HALF  = 6;
    localparam int NVEC  = 11;

    // Each entry is {command byte, data byte}. For reads the data byte is
    // the expected value.
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00A5, 16'h7F3C, 16'h4681, 16'h15FF, 16'h5099,
        16'h80A5, 16'hFD3C, 16'hC481, 16'h97FF, 16'hD299, 16'h8400
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  csb = 1'b1;
    logic                  sclk = 1'b0;
    logic                  sdi = 1'b0;
    logic                  sdo;
    logic                  sdo_oe;
    logic [NREG-1:0]       hw_we = '0;
    logic [NREG*REG_W-1:0] hw_data = '0;
    logic [NREG*REG_W-1:0] ctrl;

    logic [REG_W-1:0] model [NREG];
    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    ser_reg_host #(.REG_W(REG_W), .NREG(NREG)) i_ser_reg_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_i     (csb),
        .sclk_i    (sclk),
        .sdi_i     (sdi),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe),
        .hw_we_i   (hw_we),
        .hw_data_i (hw_data),
        .ctrl_o    (ctrl)
    );

    task automatic check(input string req, input logic [NREG*REG_W-1:0] act,
                         input logic [NREG*REG_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*REG_W-1:0] packed_model();
        logic [NREG*REG_W-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*REG_W +: REG_W] = model[k];
        return v;
    endfunction

    // One select period: nbits bits (command, data, then ones), optional
    // hardware-strobe race on the last data bit.
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat,
                        input int nbits, input bit race,
                        output logic [7:0] rd, output int oe_bad);
        rd = '0;
        oe_bad = 0;
        @(negedge clk);
        csb = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi  = (i < 8) ? cmd[7-i] : ((i < 16) ? dat[15-i] : 1'b1);
            repeat (HALF) @(negedge clk);
            if (cmd[7] && i >= 8 && i < 16) begin
                rd[15-i] = sdo;
                if (!sdo_oe) oe_bad++;
            end else if (sdo_oe) begin
                oe_bad++;
            end
            sclk = 1'b1;
            if (race && i == 15) begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                hw_we = '0;
                repeat (HALF - 5) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
        end
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        csb = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int         bad;
        for (int k = 0; k < NREG; k++) model[k] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 regs", ctrl, '0);
        check("R1 oe", {255'd0, sdo_oe}, '0);
        check("R1 sdo", {255'd0, sdo}, '0);

        // Vector table: writes (R2) then reads (R3), oe framing (R4)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] c;
            logic [7:0] d;
            c = VEC[v][15:8];
            d = VEC[v][7:0];
            xfer(c, d, 16, 1'b0, rd, bad);
            if (!c[7]) begin
                model[c[6:2]] = d;
                check("R2 write", ctrl, packed_model());
            end else begin
                check("R3 read", {248'd0, rd}, {248'd0, d});
            end
            check("R4 oe framing", bad, 0);
        end

        // R5: write aborted after 6 data bits leaves register 20 alone
        xfer(8'h50, 8'h00, 14, 1'b0, rd, bad);
        check("R5 partial write", ctrl, packed_model());

        // R4: read aborted mid data, oe must drop with select high
        xfer(8'h80, 8'h00, 11, 1'b0, rd, bad);
        check("R4 oe after abort", {255'd0, sdo_oe}, '0);
        check("R4 sdo after abort", {255'd0, sdo}, '0);

        // R6: command aborted after 3 bits, next write decodes from bit 0
        xfer(8'h1C, 8'hEE, 3, 1'b0, rd, bad);
        check("R6 aborted cmd no effect", ctrl, packed_model());
        xfer(8'h1C, 8'h3C, 16, 1'b0, rd, bad);
        model[7] = 8'h3C;
        check("R6 write after abort", ctrl, packed_model());

        // R7: 24 clocks, trailing ones must not write register 3 or 4
        xfer(8'h0C, 8'h5A, 24, 1'b0, rd, bad);
        model[3] = 8'h5A;
        check("R7 trailing bits", ctrl, packed_model());
        check("R7 oe trailing", bad, 0);

        // R8: hardware load of register 9, then serial readback
        @(negedge clk);
        hw_data[9*REG_W +: REG_W] = 8'h77;
        hw_we[9] = 1'b1;
        @(negedge clk);
        hw_we = '0;
        model[9] = 8'h77;
        check("R8 hw load", ctrl, packed_model());
        xfer(8'hA4, 8'h00, 16, 1'b0, rd, bad);
        check("R8 hw readback", {248'd0, rd}, 256'h77);

        // R8: host write and hw load on register 12 in the same clock
        @(negedge clk);
        hw_data[12*REG_W +: REG_W] = 8'h11;
        hw_we[12] = 1'b1;
        xfer(8'h30, 8'hE7, 16, 1'b1, rd, bad);
        model[12] = 8'hE7;
        check("R8 host priority", ctrl, packed_model());

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule